// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer

This block is a watchdog timer that software controls through four 32-bit words on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. Once software turns the watchdog on, a down-counter starts from a power-of-two period picked by a 4-bit code. Software must keep reloading it by writing a fixed key value. If the count runs out, the block responds in one of two ways. It can drive a fixed-length system reset pulse. Or it can first raise an interrupt, which gives software one more full period to react before the reset fires.

A separate code picks the length of the very first period after the timer is turned on. Every later reload uses the running code. A register write cannot turn the timer off again; only the block's own reset stops it. Both configuration words read back exactly the bits that were stored, so software can save them and write them back later. For fast simulation, a parameter lowers every period exponent by a fixed amount.

Top module: `wdt_top`

## Requirements
- R1: After reset, every register reads 0 and both `irq_o` and `sys_rst_o` are low.
- R2: Word 0 (address 0x0) holds the enable in bit 0 and the response mode in bit 1 (0 = reset, 1 = interrupt). Word 1 (address 0x4) holds the running code in bits [3:0] and the initial code in bits [7:4]. Both words read back the stored bits, and all other bits read 0. A read of address 0xC returns 0, and addresses whose two low bits are not zero are neither written nor read.
- R3: While the timer is off, the count reads 0, writes to the reload word have no effect, and neither output is ever asserted.
- R4: The write that sets the enable bit loads the count with 2^(16+init-SHIFT)-1 at that clock edge. From then on the count drops by one every cycle, and its value is read at address 0x8.
- R5: A cycle in which an enabled count reads 0 is followed by an expiry at the next edge. At that edge the count reloads to 2^(16+run-SHIFT)-1. A period is therefore exactly 2^(16+code-SHIFT) cycles.
- R6: A write of exactly 0x00000076 to address 0xC while the timer is on reloads the count to 2^(16+run-SHIFT)-1 and clears a pending interrupt. A write of any other value there changes nothing.
- R7: Once set, the enable bit cannot be cleared by a write. Writing it again while the timer runs does not reload the count.
- R8: In reset mode, an expiry drives `sys_rst_o` high from the expiry edge for exactly RST_LEN cycles.
- R9: In interrupt mode, the first expiry sets `irq_o`, leaves `sys_rst_o` low and keeps counting. A second expiry with no reload in between starts the reset pulse and clears `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| bus_addr | input | 4 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Pending first-expiry interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
On every cycle, the assertions check four things. The enable stays on once set. The count stays at 0 while the timer is off. A running count either steps down by one or reloads to the running period on an expiry or a valid key. The reset pulse never outlasts RST_LEN and only starts on an expiry. The exact cycle of expiry for each pair of codes can only be shown by the bench's scenarios. The same holds for three other behaviours: that wrong keys leave the count alone, that timely reloads keep the reset away, and the full interrupt-then-reset sequence.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_0076;
    localparam int BASE_EXP = 16;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_RANGE = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_KICK  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RESP_RESET = 1'b0,
        RESP_IRQ   = 1'b1
    } resp_mode_e;

    typedef struct packed {
        resp_mode_e mode;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] init_code;
        logic [3:0] run_code;
    } range_t;

    typedef struct packed {
        logic arm;
        logic kick;
    } cmd_t;

    function automatic int period_exp(input logic [3:0] code, input int shift);
        return BASE_EXP + int'(code) - shift;
    endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output range_t            range,
    output cmd_t              cmd
);
    reg_sel_e sel;
    logic     aligned;
    logic     wr_ctrl, wr_range, wr_kick;

    assign sel      = reg_sel_e'(bus_addr[3:2]);
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_ctrl  = bus_we && aligned && (sel == SEL_CTRL);
    assign wr_range = bus_we && aligned && (sel == SEL_RANGE);
    assign wr_kick  = bus_we && aligned && (sel == SEL_KICK);

    assign cmd.arm  = wr_ctrl && bus_wdata[0] && !ctrl.en;
    assign cmd.kick = wr_kick && (bus_wdata == KICK_KEY) && ctrl.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '{mode: RESP_RESET, en: 1'b0};
            range <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en   <= ctrl.en | bus_wdata[0];
                ctrl.mode <= resp_mode_e'(bus_wdata[1]);
            end
            if (wr_range) begin
                range <= bus_wdata[7:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (sel)
                SEL_CTRL:  bus_rdata = DATA_W'(ctrl);
                SEL_RANGE: bus_rdata = DATA_W'(range);
                SEL_COUNT: bus_rdata = DATA_W'(cnt);
                SEL_KICK:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int SHIFT = 14,
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  cmd_t             cmd,
    input  range_t           range,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    logic [CNT_W-1:0] init_load, run_load;

    always_comb begin
        init_load = (CNT_W'(1) << period_exp(range.init_code, SHIFT)) - CNT_W'(1);
        run_load  = (CNT_W'(1) << period_exp(range.run_code, SHIFT)) - CNT_W'(1);
    end

    assign expire = en && (cnt == '0) && !cmd.kick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.arm) begin
            cnt <= init_load;
        end else if (cmd.kick || expire) begin
            cnt <= run_load;
        end else if (en) begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdt_response.sv
module wdt_response
    import wdt_pkg::*;
#(
    parameter int RST_LEN = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       expire,
    input  logic       kick,
    input  resp_mode_e mode,
    output logic       irq,
    output logic       sys_rst
);
    localparam int PW = $clog2(RST_LEN + 1);

    logic [PW-1:0] pulse_left;
    logic          fire;

    assign fire    = expire && ((mode == RESP_RESET) || irq);
    assign sys_rst = (pulse_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq        <= 1'b0;
            pulse_left <= '0;
        end else begin
            if (kick || fire) begin
                irq <= 1'b0;
            end else if (expire) begin
                irq <= 1'b1;
            end
            if (fire) begin
                pulse_left <= PW'(RST_LEN);
            end else if (pulse_left != '0) begin
                pulse_left <= pulse_left - PW'(1);
            end
        end
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int SHIFT   = 0,
    parameter int RST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    localparam int CNT_W = BASE_EXP + 16 - SHIFT;

    ctrl_t            ctrl;
    range_t           range;
    cmd_t             cmd;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             en_w;
    logic             mode_w;
    logic             kick_w;
    logic [3:0]       run_code_w;

    assign en_w       = ctrl.en;
    assign mode_w     = ctrl.mode;
    assign kick_w     = cmd.kick;
    assign run_code_w = range.run_code;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .range     (range),
        .cmd       (cmd)
    );

    wdt_counter #(.SHIFT(SHIFT), .CNT_W(CNT_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .en     (ctrl.en),
        .cmd    (cmd),
        .range  (range),
        .cnt    (cnt),
        .expire (expire)
    );

    wdt_response #(.RST_LEN(RST_LEN)) u_resp (
        .clk     (clk),
        .rst     (rst),
        .expire  (expire),
        .kick    (cmd.kick),
        .mode    (ctrl.mode),
        .irq     (irq_o),
        .sys_rst (sys_rst_o)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int SHIFT   = 0,
    parameter int CNT_W   = 32,
    parameter int RST_LEN = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             mode,
    input logic             kick,
    input logic [3:0]       run_code,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic             sys_rst
);
    logic [31:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst || !sys_rst) hi_len <= '0;
        else                 hi_len <= hi_len + 32'd1;
    end

    function automatic logic [CNT_W-1:0] run_load(input logic [3:0] code);
        return (CNT_W'(1) << (16 + int'(code) - SHIFT)) - CNT_W'(1);
    endfunction

    // R7
    en_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> en);

    // R3
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (cnt == '0) && !sys_rst && !irq);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt != '0 && !kick) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R5
    expiry_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == '0 && !kick) |=> (cnt == run_load($past(run_code))));

    // R6
    kick_reload_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> (!irq && cnt == run_load($past(run_code))));

    // R8
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst |-> (hi_len < 32'(RST_LEN)));

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |-> $past(en && cnt == '0));

    // R9
    irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(mode));
endmodule

bind wdt_top wdt_checker #(.SHIFT(SHIFT), .CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en_w),
    .mode     (mode_w),
    .kick     (kick_w),
    .run_code (run_code_w),
    .cnt      (cnt),
    .irq      (irq_o),
    .sys_rst  (sys_rst_o)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
    localparam int CLK_PERIOD = 10;
    localparam int SHIFT      = 14;
    localparam int RST_LEN    = 8;
    localparam int NVEC       = 4;
    // each entry: {init_code, run_code}
    localparam logic [7:0] VEC [NVEC] = '{8'h01, 8'h20, 8'h33, 8'h14};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    wdt_top #(.SHIFT(SHIFT), .RST_LEN(RST_LEN)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int per(input int code);
        return 1 << (16 + code - SHIFT);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog timeout actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int c;
        step(3);
        do_reset();

        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 0);
        rd(4'h4, v); check("R1 range", v, 0);
        rd(4'h8, v); check("R1 count", v, 0);
        check("R1 irq", irq_o, 0);
        check("R1 sys_rst", sys_rst_o, 0);

        // R2 readback, unaligned ignored
        wr(4'h0, 32'hFFFF_FFFE);
        rd(4'h0, v); check("R2 ctrl readback", v, 2);
        wr(4'h4, 32'hABCD_EF5A);
        rd(4'h4, v); check("R2 range readback", v, 32'h5A);
        wr(4'h5, 32'h0000_0033);
        rd(4'h4, v); check("R2 unaligned write ignored", v, 32'h5A);
        rd(4'h5, v); check("R2 unaligned read", v, 0);
        rd(4'hC, v); check("R2 key word reads zero", v, 0);

        // R3 disabled: no counting, key ignored
        wr(4'hC, 32'h76);
        step(40);
        rd(4'h8, v); check("R3 count idle", v, 0);
        check("R3 no reset", sys_rst_o, 0);
        check("R3 no irq", irq_o, 0);

        // R4/R5/R8 table walk in reset mode
        for (int i = 0; i < NVEC; i++) begin
            int pi, pr;
            pi = per(int'(VEC[i][7:4]));
            pr = per(int'(VEC[i][3:0]));
            do_reset();
            wr(4'h4, {24'h0, VEC[i]});
            wr(4'h0, 32'h1);
            rd(4'h8, v); check("R4 initial load", v, pi - 1);
            step(pi - 1);
            rd(4'h8, v); check("R5 count at zero", v, 0);
            check("R5 no early reset", sys_rst_o, 0);
            step(1);
            check("R8 reset at expiry", sys_rst_o, 1);
            rd(4'h8, v); check("R5 reload run period", v, pr - 1);
        end

        // R6 key handling: init 3 (32), run 2 (16)
        do_reset();
        wr(4'h4, 32'h32);
        wr(4'h0, 32'h1);
        step(5);
        rd(4'h8, v); check("R4 decrement", v, 26);
        wr(4'hC, 32'h77);
        rd(4'h8, v); check("R6 wrong key ignored", v, 25);
        wr(4'hC, 32'h176);
        rd(4'h8, v); check("R6 wide wrong key ignored", v, 24);
        wr(4'hC, 32'h76);
        rd(4'h8, v); check("R6 key reload", v, 15);

        // R7 cannot disable, re-enable does not reload
        wr(4'h0, 32'h0);
        rd(4'h0, v); check("R7 enable sticky", v, 1);
        rd(4'h8, v); check("R7 still counting", v, 14);
        wr(4'h0, 32'h1);
        rd(4'h8, v); check("R7 re-enable no reload", v, 13);

        // R6 periodic kicks keep reset away
        for (int k = 0; k < 6; k++) begin
            step(10);
            wr(4'hC, 32'h76);
            check("R6 kicked, no reset", sys_rst_o, 0);
        end

        // R8 pulse length
        rd(4'h8, v); c = int'(v);
        step(c);
        check("R8 not before expiry", sys_rst_o, 0);
        step(1);
        for (int k = 0; k < RST_LEN; k++) begin
            check("R8 pulse high", sys_rst_o, 1);
            if (k < RST_LEN - 1) step(1);
        end
        step(1);
        check("R8 pulse ended", sys_rst_o, 0);
        rd(4'h8, v); check("R5 counting after expiry", v, 16 - 1 - RST_LEN);

        // R9 interrupt mode: init 1 (8), run 1 (8)
        do_reset();
        wr(4'h4, 32'h11);
        wr(4'h0, 32'h3);
        rd(4'h0, v); check("R9 mode readback", v, 3);
        step(7);
        check("R9 irq low before expiry", irq_o, 0);
        step(1);
        check("R9 irq on first expiry", irq_o, 1);
        check("R9 no reset on first expiry", sys_rst_o, 0);
        rd(4'h8, v); check("R9 keeps counting", v, 7);
        wr(4'hC, 32'h76);
        check("R6 key clears irq", irq_o, 0);
        rd(4'h8, v); check("R6 key reload irq mode", v, 7);
        step(8);
        check("R9 irq again", irq_o, 1);
        step(7);
        check("R9 no reset yet", sys_rst_o, 0);
        step(1);
        check("R9 reset on second expiry", sys_rst_o, 1);
        check("R9 irq cleared by reset", irq_o, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule